// File: doc/BRIEF.md
# Inclusive middle-level coherence line controller

This block is the per-line decision logic of a private middle cache level. That level sits between a small upper-level cache and a shared lower-level directory bank, and it keeps every line the upper level holds. Each cycle the surrounding pipeline gives the block one event that has already been classified for an addressed line, together with that line's current state. The block returns the line's next state and a vector of action strobes. The strobes request reads, writes or upgrades from the lower level, send data or acks, unblock the directory, invalidate or feed the upper level, allocate or free the line, or stall the event. Tag arrays, data storage and the network are outside the block.

Each stable state (Shared, Exclusive, Modified) comes in two forms: one where the upper level also holds a copy and one where the copy is held only locally. Before a local-only action can go ahead, a recall moves the line into a wait-for-upper transient until the upper level gives the copy up. A read miss, a write miss and a pending writeback each have transient states of their own. The logic is purely combinational. An event that has no transition from the given state raises an error flag.

Top module: `lc_line_ctrl`

## Requirements
- R1: State codes are I=0, S_up=1, S_loc=2, E_up=3, E_loc=4, M_up=5, M_loc=6, RdMiss=7, RdMissInv=8, WrMiss=9, Upgrade=10, WbWait=11, WbSink=12, S_wait=13, E_wait=14, M_wait=15, Mwb_wait=16, Upg_wait=17. Event codes are load=0, store=1, replace=2, upper_wb=3, upper_data=4, upper_ack=5, inv=6, fwd_rd=7, fwd_ex=8, recall_own=9, recall_other=10, data_part=11, data_peer=12, data_all=13, data_excl=14, ack_part=15, ack_all=16, wb_ack=17. Action bits in act_o are 0 req_rd, 1 req_wr, 2 req_upg, 3 writeback, 4 data_to_requester, 5 data_to_lower, 6 ack_to_requester, 7 unblock, 8 unblock_excl, 9 up_data, 10 up_data_excl, 11 up_stale, 12 up_inv, 13 alloc, 14 free, 15 stall. In I, a load sets req_rd and alloc and goes to RdMiss, and a store sets req_wr and alloc and goes to WrMiss.
- R2: A load in S_up or S_loc sets up_data and goes to S_up. A load in E_loc or M_loc sets up_data_excl and goes to E_up or M_up respectively.
- R3: A store in S_up or S_loc sets req_upg and goes to Upgrade. A store in E_loc or M_loc sets up_data_excl and goes to M_up. At most one of bits 0 to 3 is ever set.
- R4: In E_loc or M_loc, fwd_rd sets data_to_requester and data_to_lower and goes to S_loc. In the same states, fwd_ex sets data_to_requester and free and goes to I.
- R5: An inv in I sets ack_to_requester and stays in I. In S_loc or E_loc it sets ack_to_requester and free. In M_loc it sets data_to_lower and free. All of these end in I.
- R6: A replace in I or S_loc sets free and goes to I. In E_loc or M_loc it sets writeback and free and goes to WbWait. In WbWait, an inv sets data_to_lower, fwd_rd sets data_to_requester and data_to_lower, and fwd_ex sets data_to_requester, and each of these goes to WbSink. An inv in WbSink sets ack_to_requester. A wb_ack in WbWait or WbSink goes to I.
- R7: An inv in RdMiss or RdMissInv sets ack_to_requester and goes to RdMissInv. In RdMiss, data_all sets up_data and goes to S_up, and data_peer does the same and also sets unblock. In RdMissInv, data_all sets up_stale and goes to I, and data_peer sets up_stale and unblock and goes to I. In either state, data_excl sets up_data_excl and unblock_excl and goes to E_up.
- R8: An inv in WrMiss or Upgrade sets ack_to_requester and goes to WrMiss. In WrMiss, data_part goes to Upgrade, and data_all sets up_data_excl and unblock_excl and goes to M_up. ack_part leaves WrMiss or Upgrade unchanged with no action. In Upgrade, ack_all sets up_data_excl and unblock_excl and goes to M_up.
- R9: A recall_own or recall_other in S_up, E_up or M_up sets up_inv and goes to S_wait, E_wait or M_wait. A recall_other in Upgrade sets up_inv and goes to Upg_wait. An upper_ack sends S_wait, E_wait, M_wait and Mwb_wait to S_loc, E_loc, M_loc and M_loc, and Upg_wait to Upgrade. In E_wait or M_wait, upper_data goes to M_loc and upper_wb goes to Mwb_wait. An upper_wb in E_up or M_up goes to M_loc.
- R10: A load, store or replace in any state coded 7 or above sets only stall and leaves the state unchanged.
- R11: upper_held_o is 1 exactly in S_up, E_up, M_up, S_wait, E_wait, M_wait and Upg_wait.
- R12: Every other state and event pair sets err_o, clears act_o and returns the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| state_i | input | 5 | Current state of the addressed line |
| event_i | input | 5 | Classified event for the line |
| next_o | output | 5 | State to write back for the line |
| act_o | output | 16 | Action strobes |
| upper_held_o | output | 1 | The upper level holds a copy in the current state |
| err_o | output | 1 | No transition exists for this pair |

## Verification
The bench builds the block with the package's default counts: 18 state codes and 18 event codes, each in 5 bits. That leaves 324 valid pairs, few enough that the bench sweeps every one of them against a behavioural reference. This sweep reaches every undefined pair that should raise the error flag. A second pass feeds next_o back into state_i along an event sequence. It covers the chains of a miss, an invalidated miss, an upgrade, a recall and the ack of a writeback, and shows that the transients connect end to end.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int N_ST  = 18;
  localparam int N_EV  = 18;
  localparam int N_ACT = 16;
  localparam int ST_W  = $clog2(N_ST);
  localparam int EV_W  = $clog2(N_EV);

  typedef enum logic [ST_W-1:0] {
    ST_I = 5'd0, ST_S_UP = 5'd1, ST_S_LOC = 5'd2, ST_E_UP = 5'd3, ST_E_LOC = 5'd4,
    ST_M_UP = 5'd5, ST_M_LOC = 5'd6, ST_RDM = 5'd7, ST_RDM_INV = 5'd8, ST_WRM = 5'd9,
    ST_UPG = 5'd10, ST_WB_WAIT = 5'd11, ST_WB_SINK = 5'd12, ST_S_WAIT = 5'd13,
    ST_E_WAIT = 5'd14, ST_M_WAIT = 5'd15, ST_MWB_WAIT = 5'd16, ST_UPG_WAIT = 5'd17
  } lc_state_e;

  typedef enum logic [EV_W-1:0] {
    EV_LOAD = 5'd0, EV_STORE = 5'd1, EV_REPL = 5'd2, EV_UP_WB = 5'd3, EV_UP_DATA = 5'd4,
    EV_UP_ACK = 5'd5, EV_INV = 5'd6, EV_FWD_RD = 5'd7, EV_FWD_EX = 5'd8,
    EV_RECALL_OWN = 5'd9, EV_RECALL_OTH = 5'd10, EV_DATA_PART = 5'd11,
    EV_DATA_PEER = 5'd12, EV_DATA_ALL = 5'd13, EV_DATA_EXCL = 5'd14,
    EV_ACK_PART = 5'd15, EV_ACK_ALL = 5'd16, EV_WB_ACK = 5'd17
  } lc_event_e;

  localparam int A_REQ_RD   = 0;
  localparam int A_REQ_WR   = 1;
  localparam int A_REQ_UPG  = 2;
  localparam int A_WB       = 3;
  localparam int A_D_REQ    = 4;
  localparam int A_D_LOW    = 5;
  localparam int A_ACK      = 6;
  localparam int A_UNBL     = 7;
  localparam int A_UNBL_X   = 8;
  localparam int A_UP_DATA  = 9;
  localparam int A_UP_DATAX = 10;
  localparam int A_UP_STALE = 11;
  localparam int A_UP_INV   = 12;
  localparam int A_ALLOC    = 13;
  localparam int A_FREE     = 14;
  localparam int A_STALL    = 15;
  localparam int N_REQ      = A_WB + 1;
endpackage

// File: rtl/lc_line_stable.sv
module lc_line_stable
  import lc_pkg::*;
(
  input  lc_state_e        st_i,
  input  lc_event_e        ev_i,
  output logic             own_o,
  output lc_state_e        nxt_o,
  output logic [N_ACT-1:0] act_o,
  output logic             err_o
);
  always_comb begin
    own_o = 1'b1;
    nxt_o = st_i;
    act_o = '0;
    err_o = 1'b0;
    unique case (st_i)
      ST_I: case (ev_i)
        EV_LOAD:  begin nxt_o = ST_RDM; act_o[A_REQ_RD] = 1'b1; act_o[A_ALLOC] = 1'b1; end
        EV_STORE: begin nxt_o = ST_WRM; act_o[A_REQ_WR] = 1'b1; act_o[A_ALLOC] = 1'b1; end
        EV_REPL:  act_o[A_FREE] = 1'b1;
        EV_INV:   act_o[A_ACK] = 1'b1;
        default:  err_o = 1'b1;
      endcase
      ST_S_UP, ST_S_LOC: case (ev_i)
        EV_LOAD:  begin nxt_o = ST_S_UP; act_o[A_UP_DATA] = 1'b1; end
        EV_STORE: begin nxt_o = ST_UPG; act_o[A_REQ_UPG] = 1'b1; end
        EV_REPL, EV_INV: begin
          if (st_i == ST_S_LOC) begin
            nxt_o = ST_I;
            act_o[A_FREE] = 1'b1;
            act_o[A_ACK]  = (ev_i == EV_INV);
          end else err_o = 1'b1;
        end
        EV_RECALL_OWN, EV_RECALL_OTH: begin
          if (st_i == ST_S_UP) begin nxt_o = ST_S_WAIT; act_o[A_UP_INV] = 1'b1; end
          else err_o = 1'b1;
        end
        default: err_o = 1'b1;
      endcase
      ST_E_UP, ST_M_UP: case (ev_i)
        EV_RECALL_OWN, EV_RECALL_OTH: begin
          nxt_o = (st_i == ST_E_UP) ? ST_E_WAIT : ST_M_WAIT;
          act_o[A_UP_INV] = 1'b1;
        end
        EV_UP_WB: nxt_o = ST_M_LOC;
        default:  err_o = 1'b1;
      endcase
      ST_E_LOC, ST_M_LOC: case (ev_i)
        EV_LOAD:   begin nxt_o = (st_i == ST_E_LOC) ? ST_E_UP : ST_M_UP; act_o[A_UP_DATAX] = 1'b1; end
        EV_STORE:  begin nxt_o = ST_M_UP; act_o[A_UP_DATAX] = 1'b1; end
        EV_REPL:   begin nxt_o = ST_WB_WAIT; act_o[A_WB] = 1'b1; act_o[A_FREE] = 1'b1; end
        EV_INV: begin
          nxt_o = ST_I;
          act_o[A_FREE] = 1'b1;
          // exclusive clean copy only acks, dirty copy returns data
          if (st_i == ST_E_LOC) act_o[A_ACK] = 1'b1;
          else                  act_o[A_D_LOW] = 1'b1;
        end
        EV_FWD_RD: begin nxt_o = ST_S_LOC; act_o[A_D_REQ] = 1'b1; act_o[A_D_LOW] = 1'b1; end
        EV_FWD_EX: begin nxt_o = ST_I; act_o[A_D_REQ] = 1'b1; act_o[A_FREE] = 1'b1; end
        default:   err_o = 1'b1;
      endcase
      default: own_o = 1'b0;
    endcase
    if (err_o || !own_o) begin
      nxt_o = st_i;
      act_o = '0;
    end
  end
endmodule

// File: rtl/lc_line_miss.sv
module lc_line_miss
  import lc_pkg::*;
(
  input  lc_state_e        st_i,
  input  lc_event_e        ev_i,
  output logic             own_o,
  output lc_state_e        nxt_o,
  output logic [N_ACT-1:0] act_o,
  output logic             err_o
);
  always_comb begin
    own_o = 1'b1;
    nxt_o = st_i;
    act_o = '0;
    err_o = 1'b0;
    unique case (st_i)
      ST_RDM, ST_RDM_INV: case (ev_i)
        EV_INV: begin nxt_o = ST_RDM_INV; act_o[A_ACK] = 1'b1; end
        EV_DATA_ALL, EV_DATA_PEER: begin
          act_o[A_UNBL] = (ev_i == EV_DATA_PEER);
          if (st_i == ST_RDM) begin nxt_o = ST_S_UP; act_o[A_UP_DATA] = 1'b1; end
          else                begin nxt_o = ST_I;    act_o[A_UP_STALE] = 1'b1; end
        end
        EV_DATA_EXCL: begin nxt_o = ST_E_UP; act_o[A_UP_DATAX] = 1'b1; act_o[A_UNBL_X] = 1'b1; end
        default: err_o = 1'b1;
      endcase
      ST_WRM, ST_UPG: case (ev_i)
        EV_INV:      begin nxt_o = ST_WRM; act_o[A_ACK] = 1'b1; end
        EV_ACK_PART: ;
        EV_DATA_PART: if (st_i == ST_WRM) nxt_o = ST_UPG; else err_o = 1'b1;
        EV_DATA_ALL, EV_ACK_ALL: begin
          // data_all completes a write miss, ack_all completes an upgrade
          if ((ev_i == EV_DATA_ALL) == (st_i == ST_WRM)) begin
            nxt_o = ST_M_UP;
            act_o[A_UP_DATAX] = 1'b1;
            act_o[A_UNBL_X]   = 1'b1;
          end else err_o = 1'b1;
        end
        EV_RECALL_OTH: if (st_i == ST_UPG) begin nxt_o = ST_UPG_WAIT; act_o[A_UP_INV] = 1'b1; end
                       else err_o = 1'b1;
        default: err_o = 1'b1;
      endcase
      default: own_o = 1'b0;
    endcase
    if (err_o || !own_o) begin
      nxt_o = st_i;
      act_o = '0;
    end
  end
endmodule

// File: rtl/lc_line_evict.sv
module lc_line_evict
  import lc_pkg::*;
(
  input  lc_state_e        st_i,
  input  lc_event_e        ev_i,
  output logic             own_o,
  output lc_state_e        nxt_o,
  output logic [N_ACT-1:0] act_o,
  output logic             err_o
);
  always_comb begin
    own_o = 1'b1;
    nxt_o = st_i;
    act_o = '0;
    err_o = 1'b0;
    unique case (st_i)
      ST_WB_WAIT: case (ev_i)
        EV_WB_ACK: nxt_o = ST_I;
        EV_INV:    begin nxt_o = ST_WB_SINK; act_o[A_D_LOW] = 1'b1; end
        EV_FWD_RD: begin nxt_o = ST_WB_SINK; act_o[A_D_REQ] = 1'b1; act_o[A_D_LOW] = 1'b1; end
        EV_FWD_EX: begin nxt_o = ST_WB_SINK; act_o[A_D_REQ] = 1'b1; end
        default:   err_o = 1'b1;
      endcase
      ST_WB_SINK: case (ev_i)
        EV_WB_ACK: nxt_o = ST_I;
        EV_INV:    act_o[A_ACK] = 1'b1;
        default:   err_o = 1'b1;
      endcase
      ST_S_WAIT, ST_MWB_WAIT, ST_UPG_WAIT: case (ev_i)
        EV_UP_ACK: nxt_o = (st_i == ST_S_WAIT) ? ST_S_LOC :
                           (st_i == ST_UPG_WAIT) ? ST_UPG : ST_M_LOC;
        default:   err_o = 1'b1;
      endcase
      ST_E_WAIT, ST_M_WAIT: case (ev_i)
        EV_UP_ACK:  nxt_o = (st_i == ST_E_WAIT) ? ST_E_LOC : ST_M_LOC;
        EV_UP_DATA: nxt_o = ST_M_LOC;
        EV_UP_WB:   nxt_o = ST_MWB_WAIT;
        default:    err_o = 1'b1;
      endcase
      default: own_o = 1'b0;
    endcase
    if (err_o || !own_o) begin
      nxt_o = st_i;
      act_o = '0;
    end
  end
endmodule

// File: rtl/lc_line_ctrl.sv
module lc_line_ctrl
  import lc_pkg::*;
(
  input  logic [ST_W-1:0]  state_i,
  input  logic [EV_W-1:0]  event_i,
  output logic [ST_W-1:0]  next_o,
  output logic [N_ACT-1:0] act_o,
  output logic             upper_held_o,
  output logic             err_o
);
  localparam int N_SUB = 3;

  lc_state_e st;
  lc_event_e ev;
  assign st = lc_state_e'(state_i);
  assign ev = lc_event_e'(event_i);

  logic      [N_SUB-1:0] own;
  logic      [N_SUB-1:0] sub_err;
  lc_state_e             sub_nxt [N_SUB];
  logic      [N_ACT-1:0] sub_act [N_SUB];

  lc_line_stable u_stable (.st_i(st), .ev_i(ev), .own_o(own[0]), .nxt_o(sub_nxt[0]),
                           .act_o(sub_act[0]), .err_o(sub_err[0]));
  lc_line_miss   u_miss   (.st_i(st), .ev_i(ev), .own_o(own[1]), .nxt_o(sub_nxt[1]),
                           .act_o(sub_act[1]), .err_o(sub_err[1]));
  lc_line_evict  u_evict  (.st_i(st), .ev_i(ev), .own_o(own[2]), .nxt_o(sub_nxt[2]),
                           .act_o(sub_act[2]), .err_o(sub_err[2]));

  logic transient, core_req;
  assign transient = own[1] | own[2];
  assign core_req  = (ev == EV_LOAD) || (ev == EV_STORE) || (ev == EV_REPL);

  always_comb begin
    next_o = state_i;
    act_o  = '0;
    err_o  = ~|own;
    if (transient && core_req) begin
      act_o[A_STALL] = 1'b1;
    end else begin
      for (int i = 0; i < N_SUB; i++) begin
        if (own[i]) begin
          next_o = sub_nxt[i];
          act_o  = sub_act[i];
          err_o  = sub_err[i];
        end
      end
    end
  end

  always_comb begin
    unique case (st)
      ST_S_UP, ST_E_UP, ST_M_UP, ST_S_WAIT, ST_E_WAIT, ST_M_WAIT, ST_UPG_WAIT: upper_held_o = 1'b1;
      default: upper_held_o = 1'b0;
    endcase
  end

  always_comb begin
    assert_one_owner_R1: assert ($onehot0(own));
    if (act_o[A_STALL]) begin
      assert_stall_alone_R10: assert (act_o[A_STALL-1:0] == '0 && next_o == state_i);
    end
    if (err_o) begin
      assert_err_quiet_R12: assert (act_o == '0 && next_o == state_i);
    end
    assert_single_req_R3: assert ($countones(act_o[N_REQ-1:0]) <= 1);
    assert_alloc_free_R6: assert (!(act_o[A_ALLOC] && act_o[A_FREE]));
  end
endmodule

// File: tb/lc_line_ctrl_bench.sv
module lc_line_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [4:0]  state_i, event_i, next_o;
  logic [15:0] act_o;
  logic        upper_held_o, err_o;

  lc_line_ctrl u_lc_line_ctrl (.state_i(state_i), .event_i(event_i), .next_o(next_o),
                               .act_o(act_o), .upper_held_o(upper_held_o), .err_o(err_o));

  int checks = 0;
  int errors = 0;

  function automatic logic [15:0] b(input int k);
    return 16'(1) << k;
  endfunction

  // behavioural reference: {err, next[4:0], act[15:0]}
  function automatic logic [21:0] ref_model(input int s, input int e);
    int n = s;
    logic [15:0] a = '0;
    logic bad = 1'b0;
    if (s >= 7 && e <= 2) return {1'b0, 5'(s), b(15)};
    case (e)
      0: if (s == 0) begin n = 7; a = b(0) | b(13); end
         else if (s == 1 || s == 2) begin n = 1; a = b(9); end
         else if (s == 4) begin n = 3; a = b(10); end
         else if (s == 6) begin n = 5; a = b(10); end
         else bad = 1;
      1: if (s == 0) begin n = 9; a = b(1) | b(13); end
         else if (s == 1 || s == 2) begin n = 10; a = b(2); end
         else if (s == 4 || s == 6) begin n = 5; a = b(10); end
         else bad = 1;
      2: if (s == 0 || s == 2) begin n = 0; a = b(14); end
         else if (s == 4 || s == 6) begin n = 11; a = b(3) | b(14); end
         else bad = 1;
      3: if (s == 3 || s == 5) n = 6; else if (s == 14 || s == 15) n = 16; else bad = 1;
      4: if (s == 14 || s == 15) n = 6; else bad = 1;
      5: case (s) 13: n = 2; 14: n = 4; 15, 16: n = 6; 17: n = 10; default: bad = 1; endcase
      6: case (s)
           0: a = b(6);
           2, 4: begin n = 0; a = b(6) | b(14); end
           6: begin n = 0; a = b(5) | b(14); end
           7, 8: begin n = 8; a = b(6); end
           9, 10: begin n = 9; a = b(6); end
           11: begin n = 12; a = b(5); end
           12: a = b(6);
           default: bad = 1;
         endcase
      7: if (s == 4 || s == 6) begin n = 2; a = b(4) | b(5); end
         else if (s == 11) begin n = 12; a = b(4) | b(5); end
         else bad = 1;
      8: if (s == 4 || s == 6) begin n = 0; a = b(4) | b(14); end
         else if (s == 11) begin n = 12; a = b(4); end
         else bad = 1;
      9, 10: if (s == 1) begin n = 13; a = b(12); end
         else if (s == 3) begin n = 14; a = b(12); end
         else if (s == 5) begin n = 15; a = b(12); end
         else if (s == 10 && e == 10) begin n = 17; a = b(12); end
         else bad = 1;
      11: if (s == 9) n = 10; else bad = 1;
      12: if (s == 7) begin n = 1; a = b(7) | b(9); end
          else if (s == 8) begin n = 0; a = b(7) | b(11); end
          else bad = 1;
      13: if (s == 7) begin n = 1; a = b(9); end
          else if (s == 8) begin n = 0; a = b(11); end
          else if (s == 9) begin n = 5; a = b(8) | b(10); end
          else bad = 1;
      14: if (s == 7 || s == 8) begin n = 3; a = b(8) | b(10); end else bad = 1;
      15: if (!(s == 9 || s == 10)) bad = 1;
      16: if (s == 10) begin n = 5; a = b(8) | b(10); end else bad = 1;
      17: if (s == 11 || s == 12) n = 0; else bad = 1;
      default: bad = 1;
    endcase
    if (bad) return {1'b1, 5'(s), 16'h0};
    return {1'b0, 5'(n), a};
  endfunction

  function automatic string tag_of(input int s, input int e);
    logic [21:0] r = ref_model(s, e);
    if (r[15]) return "R10";
    if (r[21]) return "R12";
    case (e)
      0: return (s == 0) ? "R1" : "R2";
      1: return (s == 0) ? "R1" : "R3";
      2, 17: return "R6";
      7, 8: return (s == 11) ? "R6" : "R4";
      6: return (s == 7 || s == 8) ? "R7" : (s == 9 || s == 10) ? "R8" : (s >= 11) ? "R6" : "R5";
      11, 12, 13, 14, 15, 16: return (s == 7 || s == 8) ? "R7" : "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic ref_upper(input int s);
    return s == 1 || s == 3 || s == 5 || (s >= 13 && s <= 15) || s == 17;
  endfunction

  task automatic compare(input int s, input int e);
    logic [21:0] r = ref_model(s, e);
    string t = tag_of(s, e);
    checks++;
    if ({err_o, next_o, act_o} !== r) begin
      errors++;
      $display("FAIL %s s=%0d e=%0d: got err=%0b next=%0d act=%h, exp err=%0b next=%0d act=%h",
               t, s, e, err_o, next_o, act_o, r[21], r[20:16], r[15:0]);
    end
    checks++;
    if (upper_held_o !== ref_upper(s)) begin
      errors++;
      $display("FAIL R11 s=%0d: got upper=%0b exp %0b", s, upper_held_o, ref_upper(s));
    end
  endtask

  task automatic apply(input int s, input int e);
    @(posedge clk);
    state_i = 5'(s);
    event_i = 5'(e);
    @(negedge clk);
    compare(s, e);
  endtask

  int walk_ev[16] = '{0, 6, 13, 1, 11, 15, 16, 9, 0, 3, 5, 7, 0, 10, 5, 2};

  initial begin
    state_i = '0;
    event_i = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 idle line: load requests read and allocates
    @(negedge clk);
    checks++;
    if (next_o !== 5'd7 || act_o !== 16'h2001 || err_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle load: got next=%0d act=%h exp next=7 act=2001", next_o, act_o);
    end
    // exhaustive sweep of every pair
    for (int s = 0; s < NS; s++)
      for (int e = 0; e < NS; e++)
        apply(s, e);
    // chained walk, next state fed back
    begin
      int cur = 0;
      for (int k = 0; k < 16; k++) begin
        apply(cur, walk_ev[k]);
        cur = int'(next_o);
      end
      checks++;
      if (cur != 0) begin
        errors++;
        $display("FAIL R6 walk end state: got %0d exp 0", cur);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule